// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 9-bit words whose write side and read side run on unrelated clocks. The storage depth is a parameter (64, 256, 512, 1024, 2048, 4096 or 8192 words). Each side reports its own status in its own clock domain. The write side reports full and almost-full. The read side reports empty and almost-empty. Both pointers are kept one bit wider than the address and cross domains as Gray code through two-flop synchronizers. Full and empty are therefore pessimistic: a side may see the buffer as fuller or emptier than it is for a few cycles after the other side moves.

Two 18-bit threshold registers set the distance from each end at which the almost flags switch. Software uses the normal data ports to reach them while `cfg_sel` is high. Each accepted write stores the next 9-bit half of a threshold. Each accepted read returns the next half. Both walks follow the same cyclic four-step order.

The write side has a valid/ready handshake. A word moves on a rising `wr_clk` edge where `wr_valid` and `wr_ready` are both high, and `wr_ready` drops when the buffer is full. The read side has two enables, and the consumer withholds a read by dropping either one. A read moves a word on a rising `rd_clk` edge where both enables are high and `empty` is low. `rd_data` is registered and shows that word from the edge onward, until the next accepted read.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low and after it rises: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, `wr_ready`=1, `rd_data`=0. Both thresholds are 7, so a read-back gives 7, 0, 7, 0.
- R2: With `cfg_sel` low, a `wr_clk` edge with `wr_valid` and `wr_ready` both high stores `wr_data`. Words leave in the order they were written.
- R3: With `cfg_sel` low, a read happens only on an `rd_clk` edge where `rd_en_a`, `rd_en_b` and not-`empty` all hold. The word is on `rd_data` after that edge. With only one enable high, `rd_data` and the read pointer do not change.
- R4: After DEPTH stored words, `full`=1 and `wr_ready`=0. A write attempted while full is dropped and changes no stored data.
- R5: A read attempted while `empty`=1 leaves `rd_data` unchanged and does not move the read pointer.
- R6: With `cfg_sel` high, each `wr_clk` edge with `wr_valid` high stores `wr_data` into the next threshold half. Step 0 is the almost-empty low half, step 1 the almost-empty high half, step 2 the almost-full low half and step 3 the almost-full high half. After step 3 the walk returns to step 0. The threshold value is high*512+low, truncated to log2(DEPTH) bits.
- R7: With `cfg_sel` high, each `rd_clk` edge with both read enables high puts the next threshold half on `rd_data`, in the same four-step cyclic order. The read-back walk has its own step counter, which starts at step 0 after reset.
- R8: Let m be the almost-full threshold. `almost_full` is 1 exactly when the word count seen on the write side is at least DEPTH−m.
- R9: Let n be the almost-empty threshold. `almost_empty` is 1 exactly when the word count seen on the read side is at most n.
- R10: After a write into an empty buffer, `empty` falls on the second `rd_clk` edge after the write edge, not before. The word can be read on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, both domains |
| cfg_sel | input | 1 | High: data ports reach the threshold registers |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Space available (not full) |
| wr_data | input | 9 | Write word or threshold half |
| full | output | 1 | Buffer full (write domain) |
| almost_full | output | 1 | Count at or above DEPTH−m (write domain) |
| rd_en_a | input | 1 | Read enable, first of two |
| rd_en_b | input | 1 | Read enable, second of two |
| rd_data | output | 9 | Registered read word or threshold half |
| empty | output | 1 | Buffer empty (read domain) |
| almost_empty | output | 1 | Count at or below n (read domain) |

## Verification
The assertions rely on three conditions on the inputs. The pointers move only while `cfg_sel` is low. `cfg_sel` and the thresholds change only while both sides are idle. Threshold registers are never written and read back in the same period. The stimulus meets these conditions: it changes `cfg_sel` only between complete transfers, loads all four halves before reading them back, and lets both synchronizers settle before it checks any flag that depends on the other domain.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W = 9;
  localparam logic [DATA_W-1:0] THR_RESET = 9'd7;

  typedef enum logic [1:0] {
    THR_AE_LO = 2'd0,
    THR_AE_HI = 2'd1,
    THR_AF_LO = 2'd2,
    THR_AF_HI = 2'd3
  } thr_step_e;

  typedef struct packed {
    logic [DATA_W-1:0] hi;
    logic [DATA_W-1:0] lo;
  } thr_word_t;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DEPTH = 256,
  parameter int DW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW:0]       rgray_sync,
  output logic              full,
  output logic              almost_full,
  output logic              mem_we,
  output logic [AW-1:0]     waddr,
  output logic [AW:0]       wbin,
  output logic [AW:0]       wgray,
  output thr_word_t         ae_thr,
  output thr_word_t         af_thr
);
  localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  thr_step_e   step_q;
  logic        push_fire, load_fire;
  logic [AW:0] wbin_nxt, rbin_s, used, af_limit;
  logic [AW-1:0] af_m;

  assign push_fire = wr_valid & ~cfg_sel & ~full;
  assign load_fire = wr_valid & cfg_sel;
  assign wbin_nxt  = wbin + {{AW{1'b0}}, push_fire};

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  assign full     = (wgray == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
  assign rbin_s   = g2b(rgray_sync);
  assign used     = wbin - rbin_s;
  assign af_m     = AW'({af_thr.hi, af_thr.lo});
  assign af_limit = DEPTH_V - {1'b0, af_m};
  assign almost_full = (used >= af_limit);

  assign mem_we = push_fire;
  assign waddr  = wbin[AW-1:0];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= THR_AE_LO;
      ae_thr <= '{hi: '0, lo: THR_RESET};
      af_thr <= '{hi: '0, lo: THR_RESET};
    end else if (load_fire) begin
      unique case (step_q)
        THR_AE_LO: ae_thr.lo <= wr_data;
        THR_AE_HI: ae_thr.hi <= wr_data;
        THR_AF_LO: af_thr.lo <= wr_data;
        THR_AF_HI: af_thr.hi <= wr_data;
      endcase
      step_q <= thr_step_e'(step_q + 2'd1);
    end
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic [AW:0]       wgray_sync,
  input  logic [DATA_W-1:0] mem_rdata,
  input  thr_word_t         ae_thr,
  input  thr_word_t         af_thr,
  output logic              empty,
  output logic              almost_empty,
  output logic [AW-1:0]     raddr,
  output logic [AW:0]       rbin,
  output logic [AW:0]       rgray,
  output logic [DATA_W-1:0] rd_data
);
  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  thr_step_e     step_q;
  logic          rd_req, pop_fire, peek_fire;
  logic [AW:0]   rbin_nxt, used;
  logic [AW-1:0] ae_n;
  logic [DATA_W-1:0] thr_half;

  assign rd_req    = rd_en_a & rd_en_b;
  assign pop_fire  = rd_req & ~cfg_sel & ~empty;
  assign peek_fire = rd_req & cfg_sel;
  assign rbin_nxt  = rbin + {{AW{1'b0}}, pop_fire};

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  assign empty        = (rgray == wgray_sync);
  assign used         = g2b(wgray_sync) - rbin;
  assign ae_n         = AW'({ae_thr.hi, ae_thr.lo});
  assign almost_empty = (used <= {1'b0, ae_n});
  assign raddr        = rbin[AW-1:0];

  always_comb begin
    unique case (step_q)
      THR_AE_LO: thr_half = ae_thr.lo;
      THR_AE_HI: thr_half = ae_thr.hi;
      THR_AF_LO: thr_half = af_thr.lo;
      THR_AF_HI: thr_half = af_thr.hi;
    endcase
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      step_q  <= THR_AE_LO;
    end else if (pop_fire) begin
      rd_data <= mem_rdata;
    end else if (peek_fire) begin
      rd_data <= thr_half;
      step_q  <= thr_step_e'(step_q + 2'd1);
    end
  end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              almost_full,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty
);
  localparam int AW = $clog2(DEPTH);

  logic              mem_we;
  logic [AW-1:0]     waddr, raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [AW:0]       wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  thr_word_t         ae_thr, af_thr;

  dcf_mem #(.DEPTH(DEPTH), .DW(DATA_W)) u_mem (
    .wr_clk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dcf_sync #(.W(AW+1)) u_sync_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  dcf_sync #(.W(AW+1)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  dcf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .wr_valid(wr_valid),
    .wr_data(wr_data), .rgray_sync(rgray_s), .full(full),
    .almost_full(almost_full), .mem_we(mem_we), .waddr(waddr),
    .wbin(wbin), .wgray(wgray), .ae_thr(ae_thr), .af_thr(af_thr)
  );

  dcf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .rd_en_a(rd_en_a),
    .rd_en_b(rd_en_b), .wgray_sync(wgray_s), .mem_rdata(mem_rdata),
    .ae_thr(ae_thr), .af_thr(af_thr), .empty(empty),
    .almost_empty(almost_empty), .raddr(raddr), .rbin(rbin),
    .rgray(rgray), .rd_data(rd_data)
  );

  assign wr_ready = ~full;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        rst_n,
  input logic        cfg_sel,
  input logic        wr_valid,
  input logic        full,
  input logic        almost_full,
  input logic        rd_en_a,
  input logic        rd_en_b,
  input logic        empty,
  input logic        almost_empty,
  input logic [AW:0] wbin,
  input logic [AW:0] wgray,
  input logic [AW:0] rbin
);
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && wr_valid && !cfg_sel) |=> $stable(wbin)); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty && rd_en_a && rd_en_b && !cfg_sel) |=> $stable(rbin)); // R5

  AST_BOTH_ENABLES: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(rd_en_a && rd_en_b) |=> $stable(rbin)); // R3

  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R2

  AST_FULL_IN_AFULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full |-> almost_full); // R8

  AST_EMPTY_IN_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty |-> almost_empty); // R9
endmodule

bind dcfifo_pflag dcf_checker #(.DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
  .wr_valid(wr_valid), .full(full), .almost_full(almost_full),
  .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .empty(empty),
  .almost_empty(almost_empty), .wbin(wbin), .wgray(wgray), .rbin(rbin)
);

// File: tb/test_dcfifo_pflag.sv
module test_dcfifo_pflag;
  localparam int DEPTH = 64;
  localparam int NVEC  = 11;
  // bit 9: 1 = read and expect, 0 = write; bits 8:0 data
  localparam logic [9:0] VEC [NVEC] = '{
    10'h011, 10'h022, 10'h033, 10'h044, 10'h055,
    10'h211, 10'h222, 10'h233,
    10'h066, 10'h077,
    10'h244
  };

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic cfg_sel = 0, wr_valid = 0, rd_en_a = 0, rd_en_b = 0;
  logic [8:0] wr_data = '0;
  logic wr_ready, full, almost_full, empty, almost_empty;
  logic [8:0] rd_data;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [8:0] model_q[$];

  always #2 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  dcfifo_pflag #(.DEPTH(DEPTH)) i_dcfifo_pflag (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .full(full), .almost_full(almost_full), .rd_en_a(rd_en_a),
    .rd_en_b(rd_en_b), .rd_data(rd_data), .empty(empty),
    .almost_empty(almost_empty)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [8:0] d);
    @(negedge wr_clk);
    wr_valid = 1; wr_data = d;
    if (wr_ready && !cfg_sel) model_q.push_back(d);
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic rd_pulse(input bit a, input bit b);
    @(negedge rd_clk);
    rd_en_a = a; rd_en_b = b;
    @(negedge rd_clk);
    rd_en_a = 0; rd_en_b = 0;
  endtask

  task automatic pop(input string tag);
    logic [8:0] exp;
    while (empty) @(negedge rd_clk);
    exp = model_q.pop_front();
    rd_pulse(1, 1);
    chk(tag, rd_data, exp);
  endtask

  task automatic settle();
    repeat (5) @(negedge rd_clk);
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [8:0] hold;
    #1;
    chk("R1 empty in reset", empty, 1);
    chk("R1 full in reset", full, 0);
    #20 rst_n = 1;
    settle();
    chk("R1 empty", empty, 1);
    chk("R1 almost_empty", almost_empty, 1);
    chk("R1 full", full, 0);
    chk("R1 almost_full", almost_full, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 rd_data", rd_data, 0);
    cfg_sel = 1;
    rd_pulse(1, 1); chk("R1 R7 ae lo", rd_data, 7);
    rd_pulse(1, 1); chk("R1 R7 ae hi", rd_data, 0);
    rd_pulse(1, 1); chk("R1 R7 af lo", rd_data, 7);
    rd_pulse(1, 1); chk("R1 R7 af hi", rd_data, 0);
    cfg_sel = 0;

    // table walk: ordering with interleaved reads (R2, R3)
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][9]) begin
        while (empty) @(negedge rd_clk);
        void'(model_q.pop_front());
        rd_pulse(1, 1);
        chk("R2 R3 table read", rd_data, VEC[i][8:0]);
      end else push(VEC[i][8:0]);
    end
    pop("R2 tail 055"); pop("R2 tail 066"); pop("R2 tail 077");

    // R10 first-word latency
    settle();
    push(9'h1A5);
    chk("R10 empty not immediate", empty, 1);
    n = 0;
    while (empty && n < 10) begin @(negedge rd_clk); n++; end
    chk("R10 empty falls within 3 rd cycles", int'(n <= 3 && n >= 1), 1);
    // R3 one enable only
    hold = rd_data;
    rd_pulse(1, 0);
    chk("R3 single enable a keeps data", rd_data, hold);
    rd_pulse(0, 1);
    chk("R3 single enable b keeps data", rd_data, hold);
    chk("R3 still not empty", empty, 0);
    pop("R10 first word");

    // R5 read while empty
    settle();
    hold = rd_data;
    rd_pulse(1, 1);
    chk("R5 empty read keeps data", rd_data, hold);
    push(9'h0C3);
    pop("R5 pointer unmoved");

    // R6 load thresholds, R7 read-back, wrap
    settle();
    cfg_sel = 1;
    push(9'd3); push(9'd0); push(9'd5); push(9'd0);
    push(9'd4);
    push(9'd0); push(9'd5); push(9'd0);
    rd_pulse(1, 1); chk("R6 R7 wrapped ae lo", rd_data, 4);
    rd_pulse(1, 1); chk("R6 R7 ae hi", rd_data, 0);
    rd_pulse(1, 1); chk("R6 R7 af lo", rd_data, 5);
    rd_pulse(1, 1); chk("R6 R7 af hi", rd_data, 0);
    rd_pulse(1, 1); chk("R7 read-back wraps", rd_data, 4);
    cfg_sel = 0;
    chk("R6 load left buffer empty", empty, 1);

    // R9 almost_empty with n=4
    for (int i = 0; i < 4; i++) push(9'(i + 9'h100));
    settle();
    chk("R9 count 4 almost_empty", almost_empty, 1);
    chk("R9 count 4 not empty", empty, 0);
    push(9'h104);
    settle();
    chk("R9 count 5 not almost_empty", almost_empty, 0);
    for (int i = 0; i < 5; i++) pop("R9 drain");
    settle();

    // R8 almost_full with m=5, R4 full and overflow
    for (int i = 0; i < 58; i++) push(9'(i + 9'h040));
    chk("R8 count 58 not almost_full", almost_full, 0);
    push(9'h07A);
    chk("R8 count 59 almost_full", almost_full, 1);
    chk("R8 count 59 not full", full, 0);
    for (int i = 0; i < 5; i++) push(9'(i + 9'h080));
    chk("R4 full at depth", full, 1);
    chk("R4 wr_ready low", wr_ready, 0);
    push(9'h1FF);
    chk("R4 still full", full, 1);
    settle();
    for (int i = 0; i < DEPTH; i++) pop("R4 drain order");
    chk("R4 empty after depth reads", empty, 1);
    chk("R4 overflow word dropped", int'(model_q.size()), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule